// File: doc/BRIEF.md
# Programmable BCD Frequency Divider

The block divides an input clock by a ratio N in the range 1 to 99. The ratio is given as a packed BCD number with one 4-bit digit per decade. The count is held in a chain of BCD decades that share the input clock and count downward. Each decade passes an active-low borrow to the next higher decade. When every decade reads zero, the borrow out of the top decade marks the terminal state. On the following edge all decades reload together, so one period is exactly N input cycles.

The output `tick` is a one-cycle, clock-enable style pulse that is synchronous to the input clock. It is high while the count is all zero, which gives one pulse per N input cycles. A new ratio is picked up only at a reload, so a period that is running is never cut short or stretched. Some ratios are invalid: a ratio of zero, or any digit above 9. These are reported on `ratio_err` and are run as a ratio of 1. The current count is brought out as BCD so that the sequence can be observed.

Top module: `bcd_freq_divider`

## Requirements
- R1: While `rst` is high on a clock edge, the count is loaded with N-1 in BCD, where N is the present ratio after sanitising, and `tick` is held low.
- R2: When a valid ratio N is held, `tick` is high for exactly one cycle in every N cycles.
- R3: Away from a reload, each edge lowers the units digit by one, and a units digit of 0 becomes 9 on the same edge.
- R4: The tens digit (`count_bcd[7:4]`) changes only on an edge where the units digit (`count_bcd[3:0]`) reads 0; at that edge it drops by one. At every other edge outside a reload it holds.
- R5: `tick` is high exactly when the count reads 00. On the next edge the count becomes N-1, with N sampled from `ratio_bcd` at that edge.
- R6: A change of `ratio_bcd` in the middle of a period leaves the running countdown untouched. The new ratio is first used at the next reload.
- R7: A ratio of 00 sets `ratio_err` to 1 and is run as N=1, so `tick` is high on every cycle after the reload.
- R8: A digit greater than 9 (for example 4'hA in the tens position) sets `ratio_err` to 1 and is run as N=1. When both digits are 0 to 9 and not both zero, `ratio_err` is 0.
- R9: The largest ratio, 99 (8'h99), gives exactly one `tick` every 99 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; loads the ratio |
| ratio_bcd | input | 8 | Divide ratio as BCD: [3:0] units, [7:4] tens |
| tick | output | 1 | One-cycle pulse per N input cycles |
| ratio_err | output | 1 | High while the ratio is zero or holds a non-BCD digit |
| count_bcd | output | 8 | Present count as BCD: [3:0] units, [7:4] tens |

## Verification
Ratios are chosen so that each one exercises a different part of the logic:
- A ratio of 25 makes the units decade wrap from 0 to 9 while the tens decade holds and then steps.
- A ratio of 10 has a units digit of 0, so the reload value needs a borrow from the tens digit.
- Ratios of 1 and 2 stress back-to-back reloads.
- A ratio of 99 exercises the longest period.

A ratio change in the middle of a period shows whether the new value leaks in before the reload. Zero and non-BCD ratios show whether invalid inputs fall back to a pulse on every cycle.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;

    localparam int DIG_W = 4;
    localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

    typedef logic [DIG_W-1:0] digit_t;

    typedef struct packed {
        logic load;
        logic cin_n;
    } decade_ctrl_t;

    function automatic logic digit_valid(digit_t d);
        return d <= DIG_MAX;
    endfunction

    function automatic digit_t digit_down(digit_t d);
        return (d == '0) ? DIG_MAX : d - digit_t'(1);
    endfunction

endpackage

// File: rtl/bcd_ratio_guard.sv
module bcd_ratio_guard
    import bcd_div_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic [DIGITS*DIG_W-1:0] ratio_in,
    output logic [DIGITS*DIG_W-1:0] reload_val,
    output logic                    err
);
    localparam int W = DIGITS * DIG_W;

    logic          any_bad;
    logic          all_zero;
    logic [W-1:0]  ratio_ok;

    always_comb begin
        any_bad  = 1'b0;
        all_zero = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (!digit_valid(ratio_in[i*DIG_W +: DIG_W])) any_bad = 1'b1;
            if (ratio_in[i*DIG_W +: DIG_W] != '0) all_zero = 1'b0;
        end
        err      = any_bad | all_zero;
        ratio_ok = err ? W'(1) : ratio_in;
    end

    // Reload value is N-1 in BCD: a borrow ripples up from the units digit.
    always_comb begin
        logic borrow;
        borrow     = 1'b1;
        reload_val = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (borrow) begin
                reload_val[i*DIG_W +: DIG_W] = digit_down(ratio_ok[i*DIG_W +: DIG_W]);
                borrow = (ratio_ok[i*DIG_W +: DIG_W] == '0);
            end else begin
                reload_val[i*DIG_W +: DIG_W] = ratio_ok[i*DIG_W +: DIG_W];
            end
        end
    end

endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd_div_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  decade_ctrl_t ctrl,
    input  digit_t       load_val,
    output digit_t       q,
    output logic         cout_n
);

    always_ff @(posedge clk) begin
        if (rst || ctrl.load) begin
            q <= load_val;
        end else if (!ctrl.cin_n) begin
            q <= digit_down(q);
        end
    end

    assign cout_n = !((q == '0) && !ctrl.cin_n);

    a_r3_wrap_to_nine: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.load && !ctrl.cin_n && q == '0) |=> (q == DIG_MAX));

    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.load && !ctrl.cin_n && q != '0) |=> (q == $past(q) - digit_t'(1)));

    a_r4_hold_without_carry: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.load && ctrl.cin_n) |=> $stable(q));

endmodule

// File: rtl/bcd_freq_divider.sv
module bcd_freq_divider
    import bcd_div_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DIGITS*DIG_W-1:0] ratio_bcd,
    output logic                    tick,
    output logic                    ratio_err,
    output logic [DIGITS*DIG_W-1:0] count_bcd
);
    localparam int W = DIGITS * DIG_W;

    logic [W-1:0]    reload_val;
    logic [DIGITS:0] chain_n;
    logic            terminal;

    bcd_ratio_guard #(.DIGITS(DIGITS)) u_guard (
        .ratio_in   (ratio_bcd),
        .reload_val (reload_val),
        .err        (ratio_err)
    );

    assign chain_n[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_decade
        decade_ctrl_t ctrl;
        assign ctrl.load  = terminal;
        assign ctrl.cin_n = chain_n[g];

        bcd_decade u_dec (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl),
            .load_val (reload_val[g*DIG_W +: DIG_W]),
            .q        (count_bcd[g*DIG_W +: DIG_W]),
            .cout_n   (chain_n[g+1])
        );
    end

    // The borrow leaving the top decade is low only when every digit is zero.
    assign terminal = !chain_n[DIGITS];
    assign tick     = terminal && !rst;

    a_r5_terminal_is_zero: assert property (@(posedge clk) disable iff (rst)
        tick |-> (count_bcd == '0));

    a_r5_reload_in_range: assert property (@(posedge clk) disable iff (rst)
        (tick && !ratio_err) |=> (count_bcd < ratio_bcd || $past(ratio_bcd) != ratio_bcd));

    a_r7_invalid_runs_as_one: assert property (@(posedge clk) disable iff (rst)
        (tick && ratio_err) |=> (count_bcd == '0));

    a_r1_no_tick_in_reset: assert property (@(posedge clk)
        rst |-> !tick);

endmodule

// File: tb/test_bcd_freq_divider.sv
`timescale 1ns/1ps
module test_bcd_freq_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] hi_i = 4'd2;
    logic [3:0] lo_i = 4'd5;
    logic       tick;
    logic       ratio_err;
    logic [7:0] count_bcd;

    int total = 0;
    int bad = 0;
    int rem = 0;
    int tick_cnt = 0;

    always #2 clk = ~clk;

    bcd_freq_divider i_bcd_freq_divider (
        .clk       (clk),
        .rst       (rst),
        .ratio_bcd ({hi_i, lo_i}),
        .tick      (tick),
        .ratio_err (ratio_err),
        .count_bcd (count_bcd)
    );

    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd2, 4'd5, 16'd60},
        '{4'd0, 4'd1, 16'd6},
        '{4'd1, 4'd0, 16'd35},
        '{4'd0, 4'd9, 16'd25},
        '{4'd0, 4'd2, 16'd9},
        '{4'd4, 4'd7, 16'd100}
    };

    function automatic logic exp_err(logic [3:0] h, logic [3:0] l);
        return (h > 4'd9) || (l > 4'd9) || (h == 4'd0 && l == 4'd0);
    endfunction

    function automatic int ratio_n(logic [3:0] h, logic [3:0] l);
        if (exp_err(h, l)) return 1;
        return int'(h) * 10 + int'(l);
    endfunction

    task automatic check(input logic ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [9:0] act;
        logic [9:0] exp;
        @(posedge clk);
        if (rst || rem == 0) rem = ratio_n(hi_i, lo_i) - 1;
        else rem = rem - 1;
        #1;
        act = {tick, ratio_err, count_bcd};
        exp = {(rem == 0) && !rst, exp_err(hi_i, lo_i), 4'(rem / 10), 4'(rem % 10)};
        if (tick) tick_cnt++;
        check(act == exp, tag, act, exp);
    endtask

    initial begin
        #(4ns * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset loads N-1 = 24 and keeps tick low
        for (int i = 0; i < 3; i++) step("R1");
        rst = 1'b0;
        // R4: tens holds 2 while units run 4..0; R3: units wrap 0 -> 9 with tens stepping
        for (int i = 0; i < 4; i++) step("R4");
        for (int i = 0; i < 2; i++) step("R3");
        // R5: run through terminal and reload
        for (int i = 0; i < 25; i++) step("R5");

        // R2: table of ratios, each held while the model tracks every cycle
        for (int v = 0; v < 6; v++) begin
            hi_i = VECS[v].hi;
            lo_i = VECS[v].lo;
            for (int c = 0; c < int'(VECS[v].cyc); c++) step("R2");
        end

        // R6: switch the ratio in mid period; countdown must continue unchanged
        hi_i = 4'd2; lo_i = 4'd0;
        while (rem != 0) step("R6");
        for (int i = 0; i < 5; i++) step("R6");
        hi_i = 4'd0; lo_i = 4'd5;
        for (int i = 0; i < 30; i++) step("R6");

        // R7: zero ratio flagged and run as one
        hi_i = 4'd0; lo_i = 4'd0;
        for (int i = 0; i < 12; i++) step("R7");

        // R8: non-BCD digits flagged and run as one
        hi_i = 4'hA; lo_i = 4'd3;
        for (int i = 0; i < 6; i++) step("R8");
        hi_i = 4'd1; lo_i = 4'hF;
        for (int i = 0; i < 6; i++) step("R8");

        // R9: ratio 99 gives two ticks in 198 cycles after a reload
        hi_i = 4'd9; lo_i = 4'd9;
        while (rem != 0) step("R9");
        tick_cnt = 0;
        for (int i = 0; i < 198; i++) step("R9");
        check(tick_cnt == 2, "R9 tick count", 10'(tick_cnt), 10'd2);

        // R1: reset in mid period reloads from the present ratio
        hi_i = 4'd3; lo_i = 4'd0;
        for (int i = 0; i < 7; i++) step("R1");
        rst = 1'b1;
        step("R1");
        step("R1");
        rst = 1'b0;
        for (int i = 0; i < 40; i++) step("R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule